// File: doc/BRIEF.md
# Audio DMA Channel Address and Count Engine

This block keeps the address and count state for one audio DMA channel. A frame is a circular buffer in memory, measured in 32-bit words. Software programs a base address and a frame word count. It also programs a sample count, which sets how many samples pass between terminal events. The block works out the next byte address, and it caps each transfer at the smallest of three limits: the bytes left in the frame, the bytes left before the next terminal event, and the budget the data path offers.

The memory master and the sample path sit outside the block. Each cycle they may offer a byte budget. When they have moved some bytes, they report the count back on the completion input. The block then advances a word index and a 2-bit byte residue, counts samples down, and pulses a terminal event when the sample countdown expires. In loop mode the index wraps to zero at the end of the frame. In single-pass mode the index stops at the last word and a sticky end flag is raised.

A parameter picks playback or record direction. The direction only sets the constant read/write qualifier that goes out with each request.

Top module: `audio_dma_counter`

## Requirements
- R1: After reset, the frame base, frame count, sample count, byte residue, end flag and terminal pulse are all zero.
- R2: Format bit 0 selects stereo and bit 1 selects 16-bit. A sample is 1 << (bit0 + bit1) bytes. The offered budget is rounded down to a whole number of samples.
- R3: The request address is base + 4 × index + residue. The index is frame count bits 31:16.
- R4: The request byte count is the minimum of three values: the frame remainder ((size − index + 1) × 4 + residue, where size is frame count bits 15:0, or 0 when the index is beyond size), the countdown bytes ((countdown + 1) << shift), and the rounded budget. A request is valid only when the channel runs, the offer is valid and this minimum is non-zero.
- R5: A completion whose byte count equals the countdown bytes gives a one-cycle terminal pulse in the next cycle. It also loads the countdown (sample count bits 31:16) from the reload value (bits 15:0).
- R6: Any other completion sets the countdown to (countdown bytes − moved − 1) >> shift, and gives no pulse.
- R7: A completion adds (moved + residue) / 4 to the index and sets the residue to (moved + residue) mod 4.
- R8: With loop-select 0 (loop mode), an index that would pass size wraps to 0.
- R9: With loop-select 1, an index that would pass size stays at size and the sticky end flag is set. While the flag is set there are no requests and completions are ignored.
- R10: A frame count write loads bits 31:16 as the index and bits 15:0 as size, clears the residue and the end flag, and overrides a completion in the same cycle.
- R11: While enable is low or pause is high, there are no requests and completions leave all state unchanged.
- R12: A reload write changes only sample count bits 15:0. A base write loads the frame base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | 1 | Channel enable |
| ch_pause | input | 1 | Channel pause |
| ch_single | input | 1 | Loop select: 0 loops, 1 stops at frame end |
| ch_fmt | input | 2 | Format: bit0 stereo, bit1 16-bit |
| base_wr | input | 1 | Frame base write strobe |
| base_wdata | input | ADDR_W | Frame base value |
| fcnt_wr | input | 1 | Frame count write strobe |
| fcnt_wdata | input | 2*IDX_W | Index (upper half) and size (lower half) |
| reload_wr | input | 1 | Sample reload write strobe |
| reload_wdata | input | IDX_W | Sample reload value |
| offer_valid | input | 1 | Data path offers a budget |
| offer_bytes | input | BUD_W | Offered byte budget |
| done_valid | input | 1 | Transfer completion |
| done_bytes | input | LEN_W | Bytes moved by the completed transfer |
| req_valid | output | 1 | Request valid |
| req_addr | output | ADDR_W | Next byte address |
| req_bytes | output | LEN_W | Byte limit of this request |
| req_write | output | 1 | 1 for record direction (memory write) |
| tc_pulse | output | 1 | Terminal-count event |
| frame_end | output | 1 | Sticky single-pass end flag |
| frame_base | output | ADDR_W | Frame base register |
| frame_count | output | 2*IDX_W | Index and size |
| sample_count | output | 2*IDX_W | Countdown and reload |
| byte_residue | output | 2 | Byte residue |

## Verification
The bound checker watches the properties that must hold on every cycle. These are: no request while idle or after single-pass end, no request larger than the offer, a zero residue after each frame count write, a sticky end flag, and a countdown equal to the reload value whenever the terminal pulse fires. The exact arithmetic can only be shown by the bench's scenarios, which compare against a bench-side model. That arithmetic covers the address sum, the three-way minimum, the countdown remainder, the index and residue carry, loop wrapping and single-pass stopping, each exercised across all four formats and at frame boundaries.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

   typedef enum logic [1:0] {
      FMT_MONO8   = 2'd0,
      FMT_STEREO8 = 2'd1,
      FMT_MONO16  = 2'd2,
      FMT_STEREO16 = 2'd3
   } smp_fmt_e;

   // log2 of bytes per sample: one step for stereo, one for 16-bit
   function automatic logic [1:0] smp_shift(input logic [1:0] fmt);
      return {1'b0, fmt[0]} + {1'b0, fmt[1]};
   endfunction

endpackage

// File: rtl/adma_req_calc.sv
module adma_req_calc #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 16,
   parameter int BUD_W  = 16,
   parameter int LEN_W  = IDX_W + 3
) (
   input  logic              run,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   input  logic [IDX_W-1:0]  size,
   input  logic [IDX_W-1:0]  cd,
   input  logic [1:0]        res,
   input  logic [1:0]        shift,
   input  logic              offer_valid,
   input  logic [BUD_W-1:0]  offer_bytes,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_bytes,
   output logic [LEN_W-1:0]  csc_bytes
);

   logic [LEN_W-1:0] words_left;
   logic [LEN_W-1:0] left_bytes;
   logic [BUD_W-1:0] smp_mask;
   logic [LEN_W-1:0] bud_ext;
   logic [LEN_W-1:0] lim_a;

   always_comb begin
      words_left = LEN_W'(size) - LEN_W'(idx) + LEN_W'(1);
      left_bytes = (idx > size) ? '0 : ((words_left << 2) + LEN_W'(res));
      csc_bytes  = (LEN_W'(cd) + LEN_W'(1)) << shift;
      smp_mask   = BUD_W'((32'd1 << shift) - 32'd1);
      bud_ext    = LEN_W'(offer_bytes & ~smp_mask);
      lim_a      = (left_bytes < csc_bytes) ? left_bytes : csc_bytes;
      req_bytes  = (bud_ext < lim_a) ? bud_ext : lim_a;
      req_valid  = run && offer_valid && (req_bytes != '0);
      req_addr   = base + (ADDR_W'(idx) << 2) + ADDR_W'(res);
   end

endmodule

// File: rtl/adma_counters.sv
module adma_counters #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 16,
   parameter int LEN_W  = IDX_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              fcnt_wr,
   input  logic [2*IDX_W-1:0] fcnt_wdata,
   input  logic              reload_wr,
   input  logic [IDX_W-1:0]  reload_wdata,
   input  logic              upd,
   input  logic [LEN_W-1:0]  moved,
   input  logic [LEN_W-1:0]  csc_bytes,
   input  logic [1:0]        shift,
   input  logic              single,
   output logic [ADDR_W-1:0] base_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [IDX_W-1:0]  size_q,
   output logic [IDX_W-1:0]  cd_q,
   output logic [IDX_W-1:0]  rl_q,
   output logic [1:0]        res_q,
   output logic              end_q,
   output logic              tc_q
);

   localparam int SUM_W = LEN_W + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] nidx;
   logic             past_end;
   logic             hit;
   logic [LEN_W-1:0] rem;
   logic [IDX_W-1:0] cd_next;

   always_comb begin
      sum      = SUM_W'(moved) + SUM_W'(res_q);
      nidx     = SUM_W'(idx_q) + (sum >> 2);
      past_end = nidx > SUM_W'(size_q);
      hit      = (moved == csc_bytes);
      rem      = csc_bytes - moved - LEN_W'(1);
      cd_next  = IDX_W'(rem >> shift);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
         size_q <= '0;
         cd_q   <= '0;
         rl_q   <= '0;
         res_q  <= '0;
         end_q  <= 1'b0;
         tc_q   <= 1'b0;
      end else begin
         tc_q <= 1'b0;
         if (base_wr)   base_q <= base_wdata;
         if (reload_wr) rl_q   <= reload_wdata;
         if (fcnt_wr) begin
            idx_q  <= fcnt_wdata[2*IDX_W-1:IDX_W];
            size_q <= fcnt_wdata[IDX_W-1:0];
            res_q  <= '0;
            end_q  <= 1'b0;
         end else if (upd) begin
            tc_q  <= hit;
            cd_q  <= hit ? rl_q : cd_next;
            res_q <= sum[1:0];
            if (past_end) begin
               if (single) begin
                  idx_q <= size_q;
                  end_q <= 1'b1;
               end else begin
                  idx_q <= '0;
               end
            end else begin
               idx_q <= nidx[IDX_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/audio_dma_counter.sv
module audio_dma_counter
   import audio_dma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 16,
   parameter int BUD_W     = 16,
   parameter bit IS_RECORD = 1'b0,
   parameter int LEN_W     = IDX_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ch_enable,
   input  logic               ch_pause,
   input  logic               ch_single,
   input  logic [1:0]         ch_fmt,
   input  logic               base_wr,
   input  logic [ADDR_W-1:0]  base_wdata,
   input  logic               fcnt_wr,
   input  logic [2*IDX_W-1:0] fcnt_wdata,
   input  logic               reload_wr,
   input  logic [IDX_W-1:0]   reload_wdata,
   input  logic               offer_valid,
   input  logic [BUD_W-1:0]   offer_bytes,
   input  logic               done_valid,
   input  logic [LEN_W-1:0]   done_bytes,
   output logic               req_valid,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [LEN_W-1:0]   req_bytes,
   output logic               req_write,
   output logic               tc_pulse,
   output logic               frame_end,
   output logic [ADDR_W-1:0]  frame_base,
   output logic [2*IDX_W-1:0] frame_count,
   output logic [2*IDX_W-1:0] sample_count,
   output logic [1:0]         byte_residue
);

   if (IDX_W < 2 || IDX_W > 24) begin : g_bad_idx
      $error("IDX_W out of range");
   end
   if (BUD_W > LEN_W) begin : g_bad_bud
      $error("BUD_W must not exceed LEN_W");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for the frame");
   end

   if (IS_RECORD) begin : g_record
      assign req_write = 1'b1;
   end else begin : g_playback
      assign req_write = 1'b0;
   end

   logic [1:0]        shift;
   logic              run;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q, size_q, cd_q, rl_q;
   logic [1:0]        res_q;
   logic              end_q;
   logic              tc_q;
   logic [LEN_W-1:0]  csc_bytes;

   assign shift = smp_shift(ch_fmt);
   assign run   = ch_enable && !ch_pause && !end_q;

   adma_req_calc #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BUD_W(BUD_W), .LEN_W(LEN_W)
   ) u_req (
      .run        (run),
      .base       (base_q),
      .idx        (idx_q),
      .size       (size_q),
      .cd         (cd_q),
      .res        (res_q),
      .shift      (shift),
      .offer_valid(offer_valid),
      .offer_bytes(offer_bytes),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_bytes  (req_bytes),
      .csc_bytes  (csc_bytes)
   );

   adma_counters #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .base_wr     (base_wr),
      .base_wdata  (base_wdata),
      .fcnt_wr     (fcnt_wr),
      .fcnt_wdata  (fcnt_wdata),
      .reload_wr   (reload_wr),
      .reload_wdata(reload_wdata),
      .upd         (done_valid && run),
      .moved       (done_bytes),
      .csc_bytes   (csc_bytes),
      .shift       (shift),
      .single      (ch_single),
      .base_q      (base_q),
      .idx_q       (idx_q),
      .size_q      (size_q),
      .cd_q        (cd_q),
      .rl_q        (rl_q),
      .res_q       (res_q),
      .end_q       (end_q),
      .tc_q        (tc_q)
   );

   assign tc_pulse     = tc_q;
   assign frame_end    = end_q;
   assign frame_base   = base_q;
   assign frame_count  = {idx_q, size_q};
   assign sample_count = {cd_q, rl_q};
   assign byte_residue = res_q;

endmodule

// File: rtl/adma_checker.sv
module adma_checker #(
   parameter int IDX_W = 16,
   parameter int BUD_W = 16,
   parameter int LEN_W = IDX_W + 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ch_enable,
   input logic               ch_pause,
   input logic               fcnt_wr,
   input logic               reload_wr,
   input logic [BUD_W-1:0]   offer_bytes,
   input logic               req_valid,
   input logic [LEN_W-1:0]   req_bytes,
   input logic               tc_pulse,
   input logic               frame_end,
   input logic [2*IDX_W-1:0] sample_count,
   input logic [1:0]         byte_residue
);

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_enable || ch_pause) |-> !req_valid);                      // R11
   AST_REQ_WITHIN_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_bytes <= LEN_W'(offer_bytes)));             // R4
   AST_RESIDUE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt_wr |=> (byte_residue == 2'd0));                           // R10
   AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !fcnt_wr) |=> frame_end);                        // R9
   AST_END_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !req_valid);                                     // R9
   AST_TC_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse && !$past(reload_wr)) |->
         (sample_count[2*IDX_W-1:IDX_W] == sample_count[IDX_W-1:0])); // R5

endmodule

bind audio_dma_counter adma_checker #(
   .IDX_W(IDX_W), .BUD_W(BUD_W), .LEN_W(LEN_W)
) u_adma_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ch_enable   (ch_enable),
   .ch_pause    (ch_pause),
   .fcnt_wr     (fcnt_wr),
   .reload_wr   (reload_wr),
   .offer_bytes (offer_bytes),
   .req_valid   (req_valid),
   .req_bytes   (req_bytes),
   .tc_pulse    (tc_pulse),
   .frame_end   (frame_end),
   .sample_count(sample_count),
   .byte_residue(byte_residue)
);

// File: tb/audio_dma_counter_bench.sv
module audio_dma_counter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int IDX_W  = 16;
   localparam int BUD_W  = 16;
   localparam int LEN_W  = IDX_W + 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               ch_enable = 1'b0, ch_pause = 1'b0, ch_single = 1'b0;
   logic [1:0]         ch_fmt = 2'd0;
   logic               base_wr = 1'b0;
   logic [ADDR_W-1:0]  base_wdata = '0;
   logic               fcnt_wr = 1'b0;
   logic [2*IDX_W-1:0] fcnt_wdata = '0;
   logic               reload_wr = 1'b0;
   logic [IDX_W-1:0]   reload_wdata = '0;
   logic               offer_valid = 1'b0;
   logic [BUD_W-1:0]   offer_bytes = '0;
   logic               done_valid = 1'b0;
   logic [LEN_W-1:0]   done_bytes = '0;
   logic               req_valid, req_write, tc_pulse, frame_end;
   logic [ADDR_W-1:0]  req_addr, frame_base;
   logic [LEN_W-1:0]   req_bytes;
   logic [2*IDX_W-1:0] frame_count, sample_count;
   logic [1:0]         byte_residue;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_dma_counter u_audio_dma_counter (
      .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_pause(ch_pause),
      .ch_single(ch_single), .ch_fmt(ch_fmt), .base_wr(base_wr),
      .base_wdata(base_wdata), .fcnt_wr(fcnt_wr), .fcnt_wdata(fcnt_wdata),
      .reload_wr(reload_wr), .reload_wdata(reload_wdata),
      .offer_valid(offer_valid), .offer_bytes(offer_bytes),
      .done_valid(done_valid), .done_bytes(done_bytes),
      .req_valid(req_valid), .req_addr(req_addr), .req_bytes(req_bytes),
      .req_write(req_write), .tc_pulse(tc_pulse), .frame_end(frame_end),
      .frame_base(frame_base), .frame_count(frame_count),
      .sample_count(sample_count), .byte_residue(byte_residue)
   );

   int n_vec = 0;
   int n_bad = 0;

   // bench model state
   longint m_base = 0, m_idx = 0, m_size = 0, m_cd = 0, m_rl = 0, m_res = 0;
   bit     m_end = 0, m_tc = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int f_shift(input logic [1:0] fmt);
      return int'(fmt[0]) + int'(fmt[1]);
   endfunction

   function automatic longint f_csc(input logic [1:0] fmt);
      return (m_cd + 1) << f_shift(fmt);
   endfunction

   function automatic longint f_req_bytes(input longint offer, input logic [1:0] fmt);
      longint left, bud, m;
      left = (m_idx > m_size) ? 0 : (((m_size - m_idx + 1) << 2) + m_res);
      bud  = offer & ~((longint'(1) << f_shift(fmt)) - 1);
      m    = (left < f_csc(fmt)) ? left : f_csc(fmt);
      return (bud < m) ? bud : m;
   endfunction

   function automatic bit f_run();
      return ch_enable && !ch_pause && !m_end;
   endfunction

   task automatic model_done(input longint moved);
      longint csc, sum, nidx;
      csc  = f_csc(ch_fmt);
      m_tc = (moved == csc);
      m_cd = m_tc ? m_rl : (((csc - moved - 1) >> f_shift(ch_fmt)) & 16'hFFFF);
      sum  = moved + m_res;
      nidx = m_idx + (sum >> 2);
      m_res = sum & 3;
      if (nidx > m_size) begin
         if (ch_single) begin m_idx = m_size; m_end = 1; end
         else m_idx = 0;
      end else m_idx = nidx;
   endtask

   task automatic chk_state(input string tag);
      chk({tag, " frame_count"},  frame_count,  (m_idx << 16) | m_size);
      chk({tag, " sample_count"}, sample_count, (m_cd << 16) | m_rl);
      chk({tag, " residue"},      byte_residue, m_res);
      chk({tag, " end"},          frame_end,    m_end);
      chk({tag, " tc"},           tc_pulse,     m_tc);
      chk({tag, " base"},         frame_base,   m_base);
   endtask

   task automatic clear_in();
      base_wr = 0; fcnt_wr = 0; reload_wr = 0; done_valid = 0; offer_valid = 0;
   endtask

   // register writes: one cycle each
   task automatic wr_base(input longint v);
      @(negedge clk); clear_in(); base_wr = 1; base_wdata = ADDR_W'(v);
      @(posedge clk); m_base = v; m_tc = 0; #2;
      chk_state("R12 base write");
   endtask

   task automatic wr_fcnt(input longint idx, input longint size);
      @(negedge clk); clear_in(); fcnt_wr = 1; fcnt_wdata = {IDX_W'(idx), IDX_W'(size)};
      @(posedge clk); m_idx = idx; m_size = size; m_res = 0; m_end = 0; m_tc = 0; #2;
      chk_state("R10 frame count write");
   endtask

   task automatic wr_reload(input longint v);
      @(negedge clk); clear_in(); reload_wr = 1; reload_wdata = IDX_W'(v);
      @(posedge clk); m_rl = v; m_tc = 0; #2;
      chk_state("R12 reload write");
   endtask

   // mode 0: full request, 1: random part of request, 2: given byte count
   task automatic step(input bit ov, input longint offer, input bit dv,
                       input int mode, input longint fixed);
      longint eb, moved;
      bit ev;
      @(negedge clk); clear_in();
      offer_valid = ov; offer_bytes = BUD_W'(offer);
      #1;
      eb = f_req_bytes(offer, ch_fmt);
      ev = f_run() && ov && (eb != 0);
      chk("R4 req_valid", req_valid, ev);
      if (ev) begin
         chk("R3 req_addr", req_addr, (m_base + (m_idx << 2) + m_res) & 32'hFFFFFFFF);
         chk("R4 req_bytes", req_bytes, eb);
      end
      case (mode)
         0: moved = eb;
         1: moved = $urandom % (eb + 1);
         default: moved = fixed;
      endcase
      done_valid = dv; done_bytes = LEN_W'(moved);
      @(posedge clk);
      m_tc = 0;
      if (dv && f_run()) model_done(moved);
      #2;
      chk_state("R7 after step");
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd24680));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1; #1;
      // R1: reset state
      chk("R1 frame_count", frame_count, 0);
      chk("R1 sample_count", sample_count, 0);
      chk("R1 residue", byte_residue, 0);
      chk("R1 end", frame_end, 0);
      chk("R1 tc", tc_pulse, 0);
      chk("R1 base", frame_base, 0);
      chk("R1 playback write flag", req_write, 0);

      // R11: disabled channel ignores offers and completions
      step(1, 20, 1, 2, 3);
      chk("R11 no residue change while disabled", byte_residue, 0);

      ch_enable = 1; ch_fmt = 2'd3;
      wr_base(32'h1000);
      wr_fcnt(2, 7);
      // R2/R3/R4: stereo 16-bit, offer 7 rounds to 4, countdown bytes 4
      @(negedge clk); clear_in(); offer_valid = 1; offer_bytes = 7; #1;
      chk("R2 rounded budget", req_bytes, 4);
      chk("R3 address", req_addr, 32'h1008);
      step(1, 7, 1, 0, 0);
      chk("R5 terminal pulse", tc_pulse, 1);
      chk("R7 index advanced", frame_count, {16'd3, 16'd7});

      wr_reload(5);
      chk("R12 reload only low half", sample_count, {16'd0, 16'd5});
      ch_fmt = 2'd0;
      step(1, 3, 1, 0, 0);   // one byte, countdown bytes 1
      chk("R5 reload loaded", sample_count, {16'd5, 16'd5});
      chk("R7 residue one", byte_residue, 1);
      @(negedge clk); clear_in(); offer_valid = 1; offer_bytes = 10; #1;
      chk("R3 address with residue", req_addr, 32'h100D);
      chk("R4 countdown limit", req_bytes, 6);
      step(1, 10, 1, 2, 2);
      chk("R6 countdown remainder", sample_count[31:16], 3);
      chk("R6 no pulse", tc_pulse, 0);
      chk("R7 residue three", byte_residue, 3);

      wr_fcnt(7, 7);
      chk("R10 residue cleared", byte_residue, 0);
      // R8: loop wrap at end of frame
      step(1, 100, 1, 0, 0);
      chk("R8 wrapped index", frame_count, {16'd0, 16'd7});

      // R9: single pass holds at end
      ch_single = 1;
      wr_fcnt(7, 7);
      step(1, 100, 1, 0, 0);
      chk("R9 end flag", frame_end, 1);
      chk("R9 index held", frame_count, {16'd7, 16'd7});
      step(1, 100, 1, 2, 2);
      chk("R9 no request after end", req_valid, 0);
      chk("R9 completion ignored", byte_residue, 0);
      ch_single = 0;
      wr_fcnt(0, 3);

      // R11: pause ignores completion
      ch_pause = 1;
      step(1, 40, 1, 2, 2);
      chk("R11 paused residue", byte_residue, 0);
      ch_pause = 0;

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom % 100;
         if (m_end || r < 3) begin
            longint sz;
            sz = $urandom % 12;
            wr_fcnt($urandom % (sz + 1), sz);
         end else if (r < 5) wr_reload($urandom % 6);
         else if (r < 8) ch_fmt = 2'($urandom % 4);
         else if (r < 10) ch_pause = ($urandom % 4 == 0);
         else if (r < 12) ch_single = ($urandom % 3 == 0);
         else if (r < 13) wr_base($urandom);
         else begin
            bit ov;
            longint off, eb;
            ov  = ($urandom % 8) != 0;
            off = $urandom % 40;
            eb  = f_req_bytes(off, ch_fmt);
            step(ov, off, ov && f_run() && eb != 0, int'($urandom % 2), 0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule